// File: doc/BRIEF.md
# Power-Management Event Status and SCI Controller

This block holds the power-management event status and enable registers, plus a small bank of general-purpose event bytes. It merges them into one level-sensitive system control interrupt (SCI). Hardware event pulses set status flags:

- a power-button press;
- a timer overflow;
- a wake request tagged with its cause;
- a general-purpose event vector.

Software reads the flags over a byte-addressed register bus. It clears a flag by writing a one to it, and it writes the enables directly.

The bus has two windows, selected by `bus_gpe`.

- **Event window (`bus_gpe`=0).** It spans four bytes and accepts 8-bit and 16-bit little-endian accesses.
- **General-purpose window (`bus_gpe`=1).** It is byte-wide. Its lower half holds status bytes and its upper half holds enable bytes.

The timer enable bit is brought out so that the separate timer block can use it. The interrupt output is registered.

Top module: `pmevt_sci_ctrl`

## Requirements
- R1: A synchronous reset clears every event status and enable bit, every general-purpose status and enable byte, and the interrupt output.
- R2: In the event window, a 16-bit access at byte offset 0 reaches the status register and one at offset 2 reaches the enable register. A 16-bit access at an odd offset, or any access at offset 4 or above, reads zero and leaves all state unchanged on a write.
- R3: A write to the status register clears exactly the bits written as 1. A byte write at offset 0 covers bits 7:0 only, and a byte write at offset 1 covers bits 15:8 only.
- R4: A write to the enable register replaces the addressed bytes with the written value. A byte write at offset 3 changes only bits 15:8, and a byte read at offsets 1 or 3 returns bits 15:8 in `bus_rdata[7:0]`.
- R5: A wake pulse always sets the wake status bit (bit 15), together with a source bit chosen by `wake_cause`:
  - cause 0 sets the clock-alarm bit (bit 10);
  - cause 1 sets the timer bit (bit 0);
  - causes 2 and 3 set the power-button bit (bit 8).
- R6: A power-button pulse sets status bit 8 only while enable bit 8 is set.
- R7: A `tmr_ovf` pulse sets status bit 0. `tmr_en` always equals enable bit 0.
- R8: `sci` is high one clock after either of two conditions holds. The first is that status AND enable AND the source mask (bits 0, 5, 8, 9 and 10) is non-zero. The second is that general-purpose status byte 0 AND enable byte 0 is non-zero. The wake bit alone never raises `sci`.
- R9: For GPE_BYTES bytes, addresses below GPE_BYTES/2 are status bytes and are cleared by writing ones. Addresses from GPE_BYTES/2 up to GPE_BYTES-1 are enable bytes and store the written value. Higher addresses read zero and ignore writes. Only `bus_wdata[7:0]` and `bus_rdata[7:0]` are used in this window.
- R10: A `gpe_evt` pulse ORs `gpe_evt_bits` into status byte 0. Enable bytes other than byte 0 never raise `sci`.
- R11: When an event sets a status bit in the same cycle that software writes a one to clear it, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_gpe | input | 1 | 0 = event window, 1 = general-purpose window |
| bus_size | input | 1 | 0 = byte, 1 = 16-bit (event window only) |
| bus_addr | input | ADDR_W | Byte offset inside the selected window |
| bus_wdata | input | 16 | Write data, little-endian lanes |
| bus_rdata | output | 16 | Read data, valid in the same cycle as the read strobe |
| tmr_ovf | input | 1 | Timer overflow pulse |
| tmr_en | output | 1 | Timer enable bit for the timer block |
| pwrbtn_evt | input | 1 | Power-button press pulse |
| wake_evt | input | 1 | Wake request pulse |
| wake_cause | input | 2 | Wake source: 0 clock alarm, 1 timer, 2/3 other |
| gpe_evt | input | 1 | General-purpose event pulse |
| gpe_evt_bits | input | 8 | Bits to set in general-purpose status byte 0 |
| sci | output | 1 | Registered level interrupt |

## Verification
Each result has its own due cycle, counted from the clock edge that samples the stimulus:

- **Read data** is combinational and is compared in the same cycle as the read strobe.
- **Register contents** change at the edge that takes a write or an event pulse, so they are read back from the cycle after that edge.
- **`sci`** is due one edge later still.
- **`tmr_en`** follows the enable register with no added delay.

The driver queues each expected value only in the cycle where it is due. The monitor compares it at the falling edge of that cycle, so no check samples near the edge that changes the value.

// File: rtl/pmevt_pkg.sv
package pmevt_pkg;

    localparam int BIT_TMR    = 0;
    localparam int BIT_GBL    = 5;
    localparam int BIT_PWRBTN = 8;
    localparam int BIT_SLPBTN = 9;
    localparam int BIT_ALARM  = 10;
    localparam int BIT_WAKE   = 15;

    localparam logic [15:0] SCI_SRC_MASK = (16'd1 << BIT_TMR) | (16'd1 << BIT_GBL) |
                                           (16'd1 << BIT_PWRBTN) | (16'd1 << BIT_SLPBTN) |
                                           (16'd1 << BIT_ALARM);

    typedef enum logic [1:0] {
        WK_ALARM = 2'd0,
        WK_TIMER = 2'd1,
        WK_MISC  = 2'd2,
        WK_MISC2 = 2'd3
    } wake_src_e;

    // Decoded event-window access: which register and which byte lanes.
    typedef struct packed {
        logic       hit_sts;
        logic       hit_en;
        logic [1:0] lane;
    } pm1_sel_t;

    function automatic logic [15:0] lane_mask(input logic [1:0] lane);
        return {{8{lane[1]}}, {8{lane[0]}}};
    endfunction

    function automatic logic [15:0] wake_bits(input wake_src_e src);
        logic [15:0] b;
        b = 16'd1 << BIT_WAKE;
        case (src)
            WK_ALARM: b[BIT_ALARM]  = 1'b1;
            WK_TIMER: b[BIT_TMR]    = 1'b1;
            default:  b[BIT_PWRBTN] = 1'b1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/pm1_window.sv
module pm1_window
    import pmevt_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              size,
    input  logic [15:0]       wdata,
    input  logic [15:0]       sts,
    input  logic [15:0]       en,
    output pm1_sel_t          sel,
    output logic [15:0]       wdata_al,
    output logic [15:0]       rdata
);
    localparam int WIN_BYTES = 4;

    logic        in_win;
    logic [1:0]  off;
    logic [15:0] src;

    assign in_win = (addr < ADDR_W'(WIN_BYTES));
    assign off    = addr[1:0];

    always_comb begin
        sel = '0;
        if (in_win) begin
            if (size) begin
                if (off == 2'd0) begin
                    sel.hit_sts = 1'b1;
                    sel.lane    = 2'b11;
                end else if (off == 2'd2) begin
                    sel.hit_en = 1'b1;
                    sel.lane   = 2'b11;
                end
            end else begin
                sel.hit_sts = ~off[1];
                sel.hit_en  = off[1];
                sel.lane    = off[0] ? 2'b10 : 2'b01;
            end
        end
    end

    assign wdata_al = (sel.lane == 2'b10) ? {wdata[7:0], 8'h00} : wdata;
    assign src      = sel.hit_sts ? sts : (sel.hit_en ? en : 16'h0000);
    assign rdata    = (sel.lane == 2'b10) ? {8'h00, src[15:8]} : (src & lane_mask(sel.lane));

endmodule

// File: rtl/pm1_regs.sv
module pm1_regs
    import pmevt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr,
    input  pm1_sel_t    sel,
    input  logic [15:0] wdata_al,
    input  logic        tmr_ovf,
    input  logic        pwrbtn_evt,
    input  logic        wake_evt,
    input  logic [1:0]  wake_cause,
    output logic [15:0] sts,
    output logic [15:0] en
);
    logic [15:0] set_v, clr_v, wmask;

    assign wmask = lane_mask(sel.lane);

    always_comb begin
        set_v = '0;
        if (tmr_ovf)                     set_v[BIT_TMR]    = 1'b1;
        if (pwrbtn_evt && en[BIT_PWRBTN]) set_v[BIT_PWRBTN] = 1'b1;
        if (wake_evt)                    set_v = set_v | wake_bits(wake_src_e'(wake_cause));
        clr_v = (wr && sel.hit_sts) ? (wdata_al & wmask) : 16'h0000;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts <= '0;
            en  <= '0;
        end else begin
            sts <= (sts & ~clr_v) | set_v;
            if (wr && sel.hit_en)
                en <= (en & ~wmask) | (wdata_al & wmask);
        end
    end

endmodule

// File: rtl/gpe_bank.sv
module gpe_bank #(
    parameter int GPE_BYTES = 4,
    parameter int ADDR_W    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              ev,
    input  logic [7:0]        ev_bits,
    output logic [7:0]        rdata,
    output logic [7:0]        sts0,
    output logic [7:0]        en0
);
    localparam int HALF = GPE_BYTES / 2;
    localparam int VW   = HALF * 8;

    logic [VW-1:0] sts_q, en_q, sts_d, en_d;

    for (genvar i = 0; i < HALF; i++) begin : g_byte
        logic hit_s, hit_e;
        logic [7:0] set_b;
        assign hit_s = acc && wr && (addr == ADDR_W'(i));
        assign hit_e = acc && wr && (addr == ADDR_W'(HALF + i));
        if (i == 0) begin : g_src
            assign set_b = ev ? ev_bits : 8'h00;
        end else begin : g_nosrc
            assign set_b = 8'h00;
        end
        assign sts_d[i*8 +: 8] = (sts_q[i*8 +: 8] & ~(hit_s ? wdata : 8'h00)) | set_b;
        assign en_d[i*8 +: 8]  = hit_e ? wdata : en_q[i*8 +: 8];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q <= '0;
            en_q  <= '0;
        end else begin
            sts_q <= sts_d;
            en_q  <= en_d;
        end
    end

    always_comb begin
        rdata = 8'h00;
        for (int i = 0; i < HALF; i++) begin
            if (addr == ADDR_W'(i))        rdata = sts_q[i*8 +: 8];
            if (addr == ADDR_W'(HALF + i)) rdata = en_q[i*8 +: 8];
        end
    end

    assign sts0 = sts_q[7:0];
    assign en0  = en_q[7:0];

endmodule

// File: rtl/sci_gen.sv
module sci_gen
    import pmevt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] sts,
    input  logic [15:0] en,
    input  logic [7:0]  gsts0,
    input  logic [7:0]  gen0,
    output logic        sci
);
    logic lvl;

    assign lvl = (|(sts & en & SCI_SRC_MASK)) || (|(gsts0 & gen0));

    always_ff @(posedge clk) begin
        if (rst) sci <= 1'b0;
        else     sci <= lvl;
    end

endmodule

// File: rtl/pmevt_sci_ctrl.sv
module pmevt_sci_ctrl
    import pmevt_pkg::*;
#(
    parameter int GPE_BYTES = 4,
    parameter int ADDR_W    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic              bus_gpe,
    input  logic              bus_size,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic              tmr_ovf,
    output logic              tmr_en,
    input  logic              pwrbtn_evt,
    input  logic              wake_evt,
    input  logic [1:0]        wake_cause,
    input  logic              gpe_evt,
    input  logic [7:0]        gpe_evt_bits,
    output logic              sci
);
    pm1_sel_t    pm1_sel;
    logic [15:0] pm1_wdata_al, pm1_rd, pm1_sts, pm1_en;
    logic [7:0]  gpe_rd, gpe_sts0, gpe_en0;
    logic        pm1_wr, gpe_acc;

    assign pm1_wr  = bus_en && bus_we && !bus_gpe;
    assign gpe_acc = bus_en && bus_gpe;

    pm1_window #(.ADDR_W(ADDR_W)) u_win (
        .addr(bus_addr), .size(bus_size), .wdata(bus_wdata),
        .sts(pm1_sts), .en(pm1_en),
        .sel(pm1_sel), .wdata_al(pm1_wdata_al), .rdata(pm1_rd)
    );

    pm1_regs u_pm1 (
        .clk(clk), .rst(rst), .wr(pm1_wr), .sel(pm1_sel), .wdata_al(pm1_wdata_al),
        .tmr_ovf(tmr_ovf), .pwrbtn_evt(pwrbtn_evt), .wake_evt(wake_evt),
        .wake_cause(wake_cause), .sts(pm1_sts), .en(pm1_en)
    );

    gpe_bank #(.GPE_BYTES(GPE_BYTES), .ADDR_W(ADDR_W)) u_gpe (
        .clk(clk), .rst(rst), .acc(gpe_acc), .wr(bus_we), .addr(bus_addr),
        .wdata(bus_wdata[7:0]), .ev(gpe_evt), .ev_bits(gpe_evt_bits),
        .rdata(gpe_rd), .sts0(gpe_sts0), .en0(gpe_en0)
    );

    sci_gen u_sci (
        .clk(clk), .rst(rst), .sts(pm1_sts), .en(pm1_en),
        .gsts0(gpe_sts0), .gen0(gpe_en0), .sci(sci)
    );

    always_comb begin
        bus_rdata = 16'h0000;
        if (bus_en && !bus_we)
            bus_rdata = bus_gpe ? {8'h00, gpe_rd} : pm1_rd;
    end

    assign tmr_en = pm1_en[BIT_TMR];

endmodule

// File: rtl/pmevt_sci_chk.sv
module pmevt_sci_chk
    import pmevt_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        bus_en,
    input logic        bus_we,
    input logic        bus_gpe,
    input logic        tmr_ovf,
    input logic        pwrbtn_evt,
    input logic        wake_evt,
    input logic [15:0] sts,
    input logic [15:0] en,
    input logic [7:0]  gs0,
    input logic [7:0]  ge0,
    input logic        sci
);
    AST_RST_CLEARS: assert property (@(posedge clk)
        rst |=> (sts == 16'h0 && en == 16'h0 && gs0 == 8'h0 && ge0 == 8'h0)); // R1

    AST_W1C_NEVER_SETS: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_we && !bus_gpe && !tmr_ovf && !pwrbtn_evt && !wake_evt)
        |=> ((sts & ~$past(sts)) == 16'h0)); // R3

    AST_WAKE_FLAG: assert property (@(posedge clk) disable iff (rst)
        wake_evt |=> sts[BIT_WAKE]); // R5

    AST_PWRBTN_GATED: assert property (@(posedge clk) disable iff (rst)
        (pwrbtn_evt && !en[BIT_PWRBTN] && !sts[BIT_PWRBTN] && !wake_evt) |=> !sts[BIT_PWRBTN]); // R6

    AST_SCI_RISE: assert property (@(posedge clk) disable iff (rst)
        ((|(sts & en & SCI_SRC_MASK)) || (|(gs0 & ge0))) |=> sci); // R8

    AST_SCI_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!(|(sts & en & SCI_SRC_MASK)) && !(|(gs0 & ge0))) |=> !sci); // R8

endmodule

bind pmevt_sci_ctrl pmevt_sci_chk u_chk (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_gpe(bus_gpe),
    .tmr_ovf(tmr_ovf), .pwrbtn_evt(pwrbtn_evt), .wake_evt(wake_evt),
    .sts(pm1_sts), .en(pm1_en), .gs0(gpe_sts0), .ge0(gpe_en0), .sci(sci)
);

// File: tb/sim_pmevt_sci_ctrl.sv
module sim_pmevt_sci_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 4;

    typedef struct {
        int          kind;   // 0 read data, 1 sci, 2 tmr_en
        logic [15:0] exp;
        string       tag;
    } item_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_en = 0, bus_we = 0, bus_gpe = 0, bus_size = 0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [15:0]       bus_wdata = '0;
    logic [15:0]       bus_rdata;
    logic              tmr_ovf = 0, tmr_en, pwrbtn_evt = 0, wake_evt = 0, gpe_evt = 0, sci;
    logic [1:0]        wake_cause = '0;
    logic [7:0]        gpe_evt_bits = '0;

    item_t q[$];
    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmevt_sci_ctrl #(.GPE_BYTES(4), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_gpe(bus_gpe),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .tmr_ovf(tmr_ovf), .tmr_en(tmr_en),
        .pwrbtn_evt(pwrbtn_evt), .wake_evt(wake_evt), .wake_cause(wake_cause),
        .gpe_evt(gpe_evt), .gpe_evt_bits(gpe_evt_bits), .sci(sci)
    );

    // Monitor: compares everything queued for this cycle.
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it = q.pop_front();
            case (it.kind)
                0:       act = bus_rdata;
                1:       act = {15'h0, sci};
                default: act = {15'h0, tmr_en};
            endcase
            n_cmp++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic g, input logic sz, input int a, input logic [15:0] d);
        bus_en = 1; bus_we = 1; bus_gpe = g; bus_size = sz;
        bus_addr = ADDR_W'(a); bus_wdata = d;
        step();
        bus_en = 0; bus_we = 0;
    endtask

    task automatic rd(input logic g, input logic sz, input int a, input logic [15:0] e, input string tag);
        item_t it;
        bus_en = 1; bus_we = 0; bus_gpe = g; bus_size = sz; bus_addr = ADDR_W'(a);
        it.kind = 0; it.exp = e; it.tag = tag;
        q.push_back(it);
        step();
        bus_en = 0;
    endtask

    task automatic chk_sci(input logic e, input string tag);
        item_t it;
        step();
        it.kind = 1; it.exp = {15'h0, e}; it.tag = tag;
        q.push_back(it);
        step();
    endtask

    task automatic chk_ten(input logic e, input string tag);
        item_t it;
        it.kind = 2; it.exp = {15'h0, e}; it.tag = tag;
        q.push_back(it);
        step();
    endtask

    task automatic wake(input logic [1:0] c);
        wake_evt = 1; wake_cause = c;
        step();
        wake_evt = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1: state after reset
        rd(0, 1, 0, 16'h0000, "R1 status after reset");
        rd(0, 1, 2, 16'h0000, "R1 enable after reset");
        rd(1, 0, 0, 16'h0000, "R1 gpe status after reset");
        chk_sci(0, "R1 sci after reset");

        // R4: enable writes and byte lanes
        wr(0, 1, 2, 16'hABCD);
        rd(0, 1, 2, 16'hABCD, "R4 enable full write");
        wr(0, 0, 3, 16'h0012);
        rd(0, 1, 2, 16'h12CD, "R4 upper byte write");
        rd(0, 0, 3, 16'h0012, "R4 upper byte read");
        rd(0, 0, 2, 16'h00CD, "R4 lower byte read");
        chk_ten(1, "R7 tmr_en follows enable bit 0");
        wr(0, 1, 2, 16'h0000);
        chk_ten(0, "R7 tmr_en cleared");

        // R6: power button gating
        pwrbtn_evt = 1; step(); pwrbtn_evt = 0;
        rd(0, 1, 0, 16'h0000, "R6 press while disabled");
        wr(0, 1, 2, 16'h0100);
        pwrbtn_evt = 1; step(); pwrbtn_evt = 0;
        rd(0, 1, 0, 16'h0100, "R6 press while enabled");
        chk_sci(1, "R8 sci from power button");

        // R3: byte-lane write-one-to-clear
        wr(0, 0, 0, 16'h00FF);
        rd(0, 1, 0, 16'h0100, "R3 low byte clear keeps high");
        wr(0, 0, 1, 16'h0001);
        rd(0, 1, 0, 16'h0000, "R3 high byte clear");
        chk_sci(0, "R8 sci drops after clear");

        // R5: wake causes
        wr(0, 1, 2, 16'h0000);
        wake(2'd0);
        rd(0, 1, 0, 16'h8400, "R5 alarm wake");
        wake(2'd1);
        rd(0, 1, 0, 16'h8401, "R5 timer wake");
        wake(2'd2);
        rd(0, 1, 0, 16'h8501, "R5 other wake");
        wr(0, 1, 0, 16'hFFFF);
        rd(0, 1, 0, 16'h0000, "R3 full clear");
        wr(0, 1, 2, 16'h8000);
        wake(2'd0);
        chk_sci(0, "R8 wake bit alone no sci");
        wr(0, 1, 0, 16'hFFFF);
        wr(0, 1, 2, 16'h0000);

        // R2: window decode, R7 timer status
        tmr_ovf = 1; step(); tmr_ovf = 0;
        rd(0, 1, 0, 16'h0001, "R7 timer overflow sets bit 0");
        rd(0, 1, 1, 16'h0000, "R2 odd 16-bit read is zero");
        rd(0, 1, 4, 16'h0000, "R2 offset 4 read is zero");
        rd(0, 0, 6, 16'h0000, "R2 offset 6 read is zero");
        wr(0, 1, 4, 16'hFFFF);
        wr(0, 1, 1, 16'hFFFF);
        wr(0, 1, 3, 16'hFFFF);
        rd(0, 1, 0, 16'h0001, "R2 ignored writes keep status");
        rd(0, 1, 2, 16'h0000, "R2 ignored writes keep enable");

        // R8 / R11
        wr(0, 1, 2, 16'h0001);
        chk_sci(1, "R8 sci from timer status");
        bus_en = 1; bus_we = 1; bus_gpe = 0; bus_size = 1; bus_addr = '0;
        bus_wdata = 16'h0001; tmr_ovf = 1;
        step();
        bus_en = 0; bus_we = 0; tmr_ovf = 0;
        rd(0, 1, 0, 16'h0001, "R11 set beats clear");
        wr(0, 1, 0, 16'h0001);
        rd(0, 1, 0, 16'h0000, "R11 clear alone");
        chk_sci(0, "R8 sci low after clear");
        wr(0, 1, 2, 16'h0000);

        // R9 / R10: general-purpose bank
        wr(1, 0, 2, 16'h003C);
        rd(1, 0, 2, 16'h003C, "R9 enable byte store");
        wr(1, 0, 1, 16'h00FF);
        rd(1, 0, 1, 16'h0000, "R9 status byte clear on zero");
        gpe_evt = 1; gpe_evt_bits = 8'hF0; step(); gpe_evt = 0;
        rd(1, 0, 0, 16'h00F0, "R10 event sets byte 0");
        chk_sci(1, "R10 sci from gpe byte 0");
        wr(1, 0, 0, 16'h0030);
        rd(1, 0, 0, 16'h00C0, "R9 status byte write-one-clear");
        chk_sci(0, "R10 sci low when masked");
        wr(1, 0, 5, 16'h00FF);
        rd(1, 0, 5, 16'h0000, "R9 out-of-range read zero");
        rd(1, 0, 3, 16'h0000, "R9 out-of-range write ignored");
        wr(1, 0, 3, 16'h00FF);
        wr(1, 0, 2, 16'h0000);
        chk_sci(0, "R10 byte 1 enable no sci");
        wr(1, 0, 2, 16'h0080);
        chk_sci(1, "R10 byte 0 enable raises sci");

        // R1: reset clears populated state
        wr(0, 1, 2, 16'hFFFF);
        rst = 1; step(); step(); rst = 0;
        rd(0, 1, 0, 16'h0000, "R1 status cleared");
        rd(0, 1, 2, 16'h0000, "R1 enable cleared");
        rd(1, 0, 0, 16'h0000, "R1 gpe status cleared");
        rd(1, 0, 2, 16'h0000, "R1 gpe enable cleared");
        rd(1, 0, 3, 16'h0000, "R1 gpe enable byte 1 cleared");
        chk_sci(0, "R1 sci cleared");

        step();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule